// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is an up-counter whose state changes only on the rising clock edge. It can be forced to zero, loaded with an arbitrary value, advanced by one, or left unchanged. These actions follow a fixed priority: a synchronous housekeeping reset, then an active-low functional clear, then an active-low parallel preset, then counting. Counting happens only when two enables are both high. The width is a parameter and defaults to 4 bits.

The two enables have different jobs. `count_en` gates the count only. `chain_en` gates the count and also reaches the carry output combinationally. `carry_out` is high when `chain_en` is high and the count is all ones. To build a wider counter, feed each stage's `carry_out` into the next stage's `chain_en`, and give all stages the same clock and the same `count_en`. The stages then count as one wide binary counter. For a shorter modulus, decode the chosen terminal value outside the block and drive `clear_n` low with it.

Top module: `sync_bin_counter`

## Requirements
- R1: With `rst` high at a rising edge, `count_q` becomes 0 whatever the other inputs are.
- R2: With `rst` low and `clear_n` low at a rising edge, `count_q` becomes 0 whatever `preset_n`, both enables and `data_in` are.
- R3: With `rst` low, `clear_n` high and `preset_n` low at a rising edge, `count_q` takes `data_in` whatever the enables are.
- R4: With `rst` low, `clear_n` and `preset_n` high and both `count_en` and `chain_en` high, `count_q` rises by one per edge and wraps from all ones to 0.
- R5: With `rst` low, `clear_n` and `preset_n` high and either enable low, `count_q` keeps its value.
- R6: `carry_out` is 1 exactly when `chain_en` is 1 and `count_q` is all ones. `count_en` has no effect on it.
- R7: A change on `chain_en` reaches `carry_out` with no clock edge in between.
- R8: Between rising edges, changes on the control and data inputs leave `count_q` unchanged.
- R9: Under the parameter `WIDTH`, the count wraps at 2^WIDTH-1, and that is also the value at which `carry_out` asserts.
- R10: Chained stages (each `carry_out` driving the next stage's `chain_en`, with a shared clock and `count_en`) count as one binary counter of the summed width.
- R11: Driving `clear_n` low while `count_q` equals a decoded value M gives a count sequence of 0 to M, then 0 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the count |
| clear_n | input | 1 | Synchronous active-low clear |
| preset_n | input | 1 | Synchronous active-low parallel load |
| count_en | input | 1 | Count enable that does not affect the carry |
| chain_en | input | 1 | Count enable that also gates `carry_out` |
| data_in | input | WIDTH | Preset value |
| count_q | output | WIDTH | Current count |
| carry_out | output | 1 | High when `chain_en` is high and the count is all ones |

## Verification
The bench builds three configurations.

- **Single 4-bit stage.** Its 16 start values are crossed with all 16 combinations of clear, preset and the two enables, so every mode, every priority case and both wraps are reached. This includes clear together with preset, and `chain_en` toggling at a count of 15.
- **Three chained 4-bit stages.** These act as a 12-bit counter and are run across the nibble boundaries and the full 12-bit wrap.
- **Single 5-bit stage.** This shows that the terminal value and the carry follow `WIDTH` rather than a fixed 15.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef struct packed {
        logic rst;
        logic clear_n;
        logic preset_n;
        logic count_en;
        logic chain_en;
    } ctl_t;

    // Fixed priority: reset, clear, preset, count, hold
    function automatic op_e pick_op(input ctl_t c);
        if (c.rst || !c.clear_n) return OP_CLEAR;
        if (!c.preset_n)         return OP_LOAD;
        if (c.count_en && c.chain_en) return OP_COUNT;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/mode_decode.sv
module mode_decode
    import cnt_pkg::*;
(
    input  ctl_t ctl,
    output op_e  op
);
    always_comb op = pick_op(ctl);
endmodule

// File: rtl/count_reg.sv
module count_reg
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  op_e              op,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] count_q
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    always_ff @(posedge clk) begin
        unique case (op)
            OP_CLEAR: count_q <= '0;
            OP_LOAD:  count_q <= data_in;
            OP_COUNT: count_q <= count_q + STEP;
            default:  count_q <= count_q;
        endcase
    end
endmodule

// File: rtl/carry_gen.sv
module carry_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count_q,
    input  logic             chain_en,
    output logic             at_top,
    output logic             carry_out
);
    always_comb begin
        at_top    = &count_q;
        carry_out = at_top & chain_en;
    end
endmodule

// File: rtl/sync_bin_counter.sv
module sync_bin_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_n,
    input  logic             preset_n,
    input  logic             count_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] count_q,
    output logic             carry_out
);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] TOPV = '1;

    ctl_t ctl;
    op_e  op;
    logic at_top;

    always_comb begin
        ctl.rst      = rst;
        ctl.clear_n  = clear_n;
        ctl.preset_n = preset_n;
        ctl.count_en = count_en;
        ctl.chain_en = chain_en;
    end

    mode_decode u_dec (.ctl(ctl), .op(op));

    count_reg #(.WIDTH(WIDTH)) u_reg (
        .clk(clk), .op(op), .data_in(data_in), .count_q(count_q)
    );

    carry_gen #(.WIDTH(WIDTH)) u_carry (
        .count_q(count_q), .chain_en(chain_en),
        .at_top(at_top), .carry_out(carry_out)
    );

    // R2: functional clear wins over preset and enables
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> count_q == '0);

    // R3: preset loads data regardless of enables
    a_r3_preset_loads: assert property (@(posedge clk) disable iff (rst)
        clear_n && !preset_n |=> count_q == $past(data_in));

    // R4: increment with modular wrap
    a_r4_counts_up: assert property (@(posedge clk) disable iff (rst)
        clear_n && preset_n && count_en && chain_en
        |=> count_q == $past(count_q) + ONE);

    // R5: hold when either enable is low
    a_r5_holds: assert property (@(posedge clk) disable iff (rst)
        clear_n && preset_n && !(count_en && chain_en) |=> $stable(count_q));

    // R6: carry only with chain enable at the top value
    a_r6_carry_gate: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> chain_en && count_q == TOPV);

    // R9: a counting step out of the carry state lands on zero
    a_r9_carry_wraps: assert property (@(posedge clk) disable iff (rst)
        carry_out && count_en && clear_n && preset_n |=> count_q == '0);
endmodule

// File: tb/sync_bin_counter_tb_top.sv
`timescale 1ns/1ps
module sync_bin_counter_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic rst = 1'b1;

    // single 4-bit stage
    logic       d_clr = 1, d_pre = 1, d_ce = 0, d_te = 0;
    logic [3:0] d_data = '0;
    logic [3:0] d_q;
    logic       d_co;

    sync_bin_counter #(.WIDTH(4)) dut_i (
        .clk(clk), .rst(rst), .clear_n(d_clr), .preset_n(d_pre),
        .count_en(d_ce), .chain_en(d_te), .data_in(d_data),
        .count_q(d_q), .carry_out(d_co)
    );

    // three chained 4-bit stages
    logic        h_clr = 1, h_pre = 1, h_ce = 0, h_te = 0;
    logic [11:0] h_data = '0;
    logic [11:0] h_q;
    logic [2:0]  h_co;
    logic [2:0]  h_te_k;

    for (genvar k = 0; k < 3; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign h_te_k[k] = h_te;
        end else begin : g_next
            assign h_te_k[k] = h_co[k-1];
        end
        sync_bin_counter #(.WIDTH(4)) u_st (
            .clk(clk), .rst(rst), .clear_n(h_clr), .preset_n(h_pre),
            .count_en(h_ce), .chain_en(h_te_k[k]), .data_in(h_data[4*k +: 4]),
            .count_q(h_q[4*k +: 4]), .carry_out(h_co[k])
        );
    end

    // 5-bit stage
    logic       w_clr = 1, w_pre = 1, w_ce = 0, w_te = 0;
    logic [4:0] w_data = '0;
    logic [4:0] w_q;
    logic       w_co;

    sync_bin_counter #(.WIDTH(5)) w_i (
        .clk(clk), .rst(rst), .clear_n(w_clr), .preset_n(w_pre),
        .count_en(w_ce), .chain_en(w_te), .data_in(w_data),
        .count_q(w_q), .carry_out(w_co)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int ref_next(int s, bit c, bit p, bit e1, bit e2, int d);
        if (!c) return 0;
        if (!p) return d;
        if (e1 && e2) return (s + 1) % 16;
        return s;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with every other input pushing elsewhere
        d_pre = 0; d_data = 4'd9; d_ce = 1; d_te = 1;
        h_pre = 0; h_data = 12'habc; w_pre = 0; w_data = 5'd7;
        tick(); tick();
        check("R1 reset 4-bit", d_q, 0);
        check("R1 reset chain", h_q, 0);
        check("R1 reset 5-bit", w_q, 0);
        rst = 0;
        d_pre = 1; d_ce = 0; d_te = 0;
        h_pre = 1; w_pre = 1;
        tick();

        // Exhaustive: every start value x every control combination
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                bit cl, pr, e1, e2;
                int d, exp;
                string req;
                d_clr = 1; d_pre = 0; d_data = 4'(s); d_ce = 0; d_te = 0;
                tick();
                cl = c[3]; pr = c[2]; e1 = c[1]; e2 = c[0];
                d = (s * 5 + c + 3) % 16;
                d_clr = cl; d_pre = pr; d_ce = e1; d_te = e2; d_data = 4'(d);
                #0.5;
                // R6 / R7: carry follows chain_en with no clock edge
                check(e2 ? "R7 carry tracks chain_en" : "R6 carry gated",
                      d_co, (e2 && s == 15) ? 1 : 0);
                exp = ref_next(s, cl, pr, e1, e2, d);
                if (!cl)             req = "R2 clear priority";
                else if (!pr)        req = "R3 preset load";
                else if (e1 && e2)   req = (s == 15) ? "R4 wrap" : "R4 count";
                else                 req = "R5 hold";
                tick();
                check(req, d_q, exp);
            end
        end

        // R7: chain_en toggling at 15, carry follows without clock
        d_clr = 1; d_pre = 0; d_data = 4'd15; d_ce = 0; d_te = 0;
        tick();
        d_pre = 1;
        for (int i = 0; i < 4; i++) begin
            d_te = i[0];
            #0.3;
            check("R7 carry toggle at top", d_co, i[0]);
        end
        d_ce = 1; d_te = 1; #0.3;
        check("R6 count_en high carry", d_co, 1);
        d_ce = 0; #0.3;
        check("R6 count_en low carry", d_co, 1);
        d_te = 0;

        // R8: glitches between edges do not alter the count
        tick();
        d_clr = 0; d_pre = 0; d_data = 4'd3; d_ce = 1; d_te = 1;
        #1;
        check("R8 no change between edges", d_q, 15);
        d_clr = 1; d_pre = 1; d_ce = 0; d_te = 0;
        tick();
        check("R8 held after glitch", d_q, 15);

        // R11: modulus 10 through decoded clear
        d_clr = 0; tick();
        d_clr = 1; d_ce = 1; d_te = 1;
        for (int i = 1; i <= 22; i++) begin
            d_clr = (d_q != 4'd9);
            tick();
            check("R11 mod-10 sequence", d_q, i % 10);
        end
        d_ce = 0; d_te = 0; d_clr = 1;

        // R10: chained stages as a 12-bit counter
        begin
            int starts[3] = '{12'h0fa, 12'h7f8, 12'hff5};
            foreach (starts[j]) begin
                h_pre = 0; h_data = 12'(starts[j]); h_ce = 0; h_te = 0;
                tick();
                h_pre = 1; h_ce = 1; h_te = 1;
                for (int n = 1; n <= 20; n++) begin
                    tick();
                    check("R10 chain count", h_q, (starts[j] + n) % 4096);
                end
                h_ce = 0;
                tick();
                check("R10 chain hold on count_en", h_q, (starts[j] + 20) % 4096);
                h_te = 0;
            end
        end

        // R9: 5-bit terminal and wrap
        w_pre = 0; w_data = 5'd29; tick();
        w_pre = 1; w_ce = 1; w_te = 1;
        #0.3;
        check("R9 no carry at 29", w_co, 0);
        tick();
        check("R9 count 30", w_q, 30);
        check("R9 no carry at 15-like 30", w_co, 0);
        tick();
        check("R9 count 31", w_q, 31);
        check("R9 carry at 31", w_co, 1);
        tick();
        check("R9 wrap to 0", w_q, 0);
        w_pre = 0; w_data = 5'd15; tick();
        w_pre = 1; #0.3;
        check("R9 no carry at 15 in 5-bit", w_co, 0);

        // R1: reset overrides counting mid-run
        rst = 1; tick();
        check("R1 reset mid-run", w_q, 0);
        rst = 0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule